// File: doc/BRIEF.md
# Character LCD Host Bus Front End

This block is the host-facing side of a character LCD controller. A host processor drives a register-select line, a read/write line, an enable strobe and an eight-bit data bus. The block brings the enable strobe into the system clock domain and decodes each access into one of four kinds: instruction write, status read, data write or data read. Toward the controller core it issues single-cycle strobes that carry the assembled byte.

The bus runs at full width or in a nibble mode. In nibble mode only the upper four data lines are used, and each byte takes two enable pulses, upper nibble first. A bus-width input from the core selects the mode at run time. Status reads return the busy flag and the seven-bit address counter.

A data register sits between the host and the display memories. A host data write loads it and also passes the byte to the core. After the host reads it, the core refills it with the contents of the next address through a fill port. Writes are captured when enable falls. Read data is presented while enable is high, and only then is the output-enable raised for the pad driver.

Top module: `lcdbus_host_if`

## Requirements
- R1: An access with select low and read/write low produces exactly one `instr_wr_stb` pulse, with `wr_byte` equal to the bus byte, after enable falls.
- R2: An access with select high and read/write low produces one `data_wr_stb` pulse carrying the byte. The data register then holds that byte, and a later data read returns it.
- R3: An access with select low and read/write high presents `{core_busy, core_addr[6:0]}` on `bus_dout` while enable is high (full-width mode).
- R4: An access with select high and read/write high presents the data register. One `data_rd_stb` pulse follows when the byte is complete. A `rd_fill_vld` cycle loads `rd_fill_byte` into the data register.
- R5: With `wide_mode`=0, a byte is built from two enable pulses. `bus_din[7:4]` of the first pulse forms bits 7:4, and `bus_din[7:4]` of the second forms bits 3:0. `bus_din[3:0]` is ignored, and no strobe fires after the first pulse.
- R6: In nibble mode, a status read places `{busy, addr[6:4]}` on `bus_dout[7:4]` during the first pulse and `addr[3:0]` during the second. `bus_dout[3:0]` reads zero.
- R7: `bus_oe` is high only while enable is high during a read access. It is low when idle and during writes.
- R8: After reset no strobe is active, `bus_oe` is low, the nibble phase is the upper nibble, and the data register reads 0x00.
- R9: Any change of `wide_mode` returns the nibble phase to the upper nibble, discarding a half-received byte.
- R10: Writes are forwarded to the core whether or not `core_busy` is set.
- R11: The three strobes are single-cycle pulses, and at most one of them is high in any cycle.
- R12: In nibble mode, a data read returns data-register bits 7:4 and then 3:0 on `bus_dout[7:4]`, and `data_rd_stb` fires only after the second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 0 write, 1 read |
| bus_en | input | 1 | Asynchronous enable strobe from host |
| bus_din | input | 8 | Data lines from host |
| bus_dout | output | 8 | Data presented to host during reads |
| bus_oe | output | 1 | Output enable for the tristate pad driver |
| wide_mode | input | 1 | Bus width from core: 1 full byte, 0 nibble |
| core_busy | input | 1 | Busy flag from core |
| core_addr | input | 7 | Address counter from core |
| rd_fill_vld | input | 1 | Core loads the data register this cycle |
| rd_fill_byte | input | 8 | Prefetched byte from the next address |
| instr_wr_stb | output | 1 | Instruction byte ready |
| data_wr_stb | output | 1 | Data byte ready |
| data_rd_stb | output | 1 | Host finished reading the data register |
| wr_byte | output | 8 | Byte carried by the write strobes |

## Verification
Four properties are checked on every cycle: the strobes are exclusive single-cycle pulses, the output enable stays low whenever a write strobe fires, the nibble phase stays clear in full-width mode and after each width change, and a fill cycle with no competing write reaches the data register. Some behaviour only the bench scenarios can show. These are the nibble order, the masking of the low data lines, the status split across two pulses, the refill then seen on the next read, and forwarding while busy.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int ADDR_W = DATA_W - 1;

    typedef enum logic [1:0] {
        ACC_INSTR_WR  = 2'b00,
        ACC_STATUS_RD = 2'b01,
        ACC_DATA_WR   = 2'b10,
        ACC_DATA_RD   = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic               valid;
        acc_kind_e          kind;
        logic [DATA_W-1:0]  bval;
    } bus_evt_t;

    function automatic acc_kind_e decode_access(input logic rs, input logic rw);
        return acc_kind_e'({rs, rw});
    endfunction

    function automatic logic is_read(input acc_kind_e k);
        return k[0];
    endfunction
endpackage

// File: rtl/lcdbus_edge_sync.sv
module lcdbus_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[LAST-1:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign level = chain[LAST];
    assign rise  = chain[LAST] & ~prev;
    assign fall  = ~chain[LAST] & prev;
endmodule

// File: rtl/lcdbus_nibble_asm.sv
module lcdbus_nibble_asm
    import lcdbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic              done,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] din,
    output bus_evt_t          evt,
    output logic              phase
);
    logic              wide_d;
    logic [NIB_W-1:0]  upper_q;
    logic              width_changed;

    assign width_changed = (wide_mode != wide_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_d  <= 1'b1;
            phase   <= 1'b0;
            upper_q <= '0;
            evt     <= '0;
        end else begin
            wide_d    <= wide_mode;
            evt.valid <= 1'b0;
            if (width_changed) begin
                phase <= 1'b0;
            end else if (done) begin
                if (wide_mode) begin
                    evt.valid <= 1'b1;
                    evt.kind  <= kind;
                    evt.bval  <= din;
                end else if (!phase) begin
                    upper_q <= din[DATA_W-1:NIB_W];
                    phase   <= 1'b1;
                end else begin
                    phase     <= 1'b0;
                    evt.valid <= 1'b1;
                    evt.kind  <= kind;
                    evt.bval  <= {upper_q, din[DATA_W-1:NIB_W]};
                end
            end
        end
    end

    // R9 / R5: phase is clear after a width change and stays clear in full-width mode
    p_phase_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (wide_mode != $past(wide_mode)) |=> !phase);
    p_wide_no_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && $past(wide_mode) && $past(wide_mode, 2)) |-> !phase);
endmodule

// File: rtl/lcdbus_read_mux.sv
module lcdbus_read_mux
    import lcdbus_pkg::*;
(
    input  acc_kind_e         kind,
    input  logic              wide_mode,
    input  logic              phase,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dreg,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] src;

    always_comb begin
        src = (kind == ACC_DATA_RD) ? dreg : {busy, addr};
        if (wide_mode)
            dout = src;
        else if (!phase)
            dout = {src[DATA_W-1:NIB_W], {NIB_W{1'b0}}};
        else
            dout = {src[NIB_W-1:0], {NIB_W{1'b0}}};
    end
endmodule

// File: rtl/lcdbus_host_if.sv
module lcdbus_host_if
    import lcdbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rs,
    input  logic              bus_rw,
    input  logic              bus_en,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic              wide_mode,
    input  logic              core_busy,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              rd_fill_vld,
    input  logic [DATA_W-1:0] rd_fill_byte,
    output logic              instr_wr_stb,
    output logic              data_wr_stb,
    output logic              data_rd_stb,
    output logic [DATA_W-1:0] wr_byte
);
    logic              en_level, en_rise, en_fall;
    acc_kind_e         kind_q;
    logic [DATA_W-1:0] din_hold;
    logic [DATA_W-1:0] dreg;
    bus_evt_t          evt;
    logic              phase;
    logic              dwr_evt;

    lcdbus_edge_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (bus_en),
        .level    (en_level),
        .rise     (en_rise),
        .fall     (en_fall)
    );

    // access kind captured as enable is seen rising; data tracked while high
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= ACC_INSTR_WR;
            din_hold <= '0;
        end else begin
            if (en_rise)  kind_q   <= decode_access(bus_rs, bus_rw);
            if (en_level) din_hold <= bus_din;
        end
    end

    lcdbus_nibble_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (wide_mode),
        .done      (en_fall),
        .kind      (kind_q),
        .din       (din_hold),
        .evt       (evt),
        .phase     (phase)
    );

    assign dwr_evt = evt.valid && (evt.kind == ACC_DATA_WR);

    always_ff @(posedge clk) begin
        if (rst)              dreg <= '0;
        else if (dwr_evt)     dreg <= evt.bval;
        else if (rd_fill_vld) dreg <= rd_fill_byte;
    end

    assign instr_wr_stb = evt.valid && (evt.kind == ACC_INSTR_WR);
    assign data_wr_stb  = dwr_evt;
    assign data_rd_stb  = evt.valid && (evt.kind == ACC_DATA_RD);
    assign wr_byte      = evt.bval;

    lcdbus_read_mux u_rmux (
        .kind      (kind_q),
        .wide_mode (wide_mode),
        .phase     (phase),
        .busy      (core_busy),
        .addr      (core_addr),
        .dreg      (dreg),
        .dout      (bus_dout)
    );

    assign bus_oe = en_level && !en_rise && is_read(kind_q);

    // R11: strobes exclusive and single-cycle
    p_stb_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({instr_wr_stb, data_wr_stb, data_rd_stb}));
    p_stb_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        (instr_wr_stb || data_wr_stb || data_rd_stb) |=>
        !(instr_wr_stb || data_wr_stb || data_rd_stb));
    // R7: pad not driven when a write completes
    p_oe_quiet_write_r7: assert property (@(posedge clk) disable iff (rst)
        (instr_wr_stb || data_wr_stb) |-> !bus_oe);
    // R4: fill reaches the data register when no write competes
    p_fill_loads_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_fill_vld && !dwr_evt) |=> (dreg == $past(rd_fill_byte)));
endmodule

// File: tb/lcdbus_host_if_tb.sv
`timescale 1ns/1ps
module lcdbus_host_if_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rs = 1'b0, rw = 1'b0, en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       oe;
    logic       wide = 1'b1;
    logic       busy = 1'b0;
    logic [6:0] ac = 7'h00;
    logic       fill_v = 1'b0;
    logic [7:0] fill_b = 8'h00;
    logic       i_stb, dw_stb, dr_stb;
    logic [7:0] wbyte;

    int checks = 0, errors = 0;
    int n_instr = 0, n_dwr = 0, n_drd = 0;
    logic [7:0] last_byte = 8'h00;
    logic       multi_stb = 1'b0;

    always #2 clk = ~clk;

    lcdbus_host_if dut_i (
        .clk(clk), .rst(rst), .bus_rs(rs), .bus_rw(rw), .bus_en(en),
        .bus_din(din), .bus_dout(dout), .bus_oe(oe), .wide_mode(wide),
        .core_busy(busy), .core_addr(ac), .rd_fill_vld(fill_v),
        .rd_fill_byte(fill_b), .instr_wr_stb(i_stb), .data_wr_stb(dw_stb),
        .data_rd_stb(dr_stb), .wr_byte(wbyte)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (i_stb)  begin n_instr++; last_byte = wbyte; end
            if (dw_stb) begin n_dwr++;   last_byte = wbyte; end
            if (dr_stb) n_drd++;
            if ((i_stb + dw_stb + dr_stb) > 1) multi_stb = 1'b1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one enable pulse; returns dout and oe sampled mid-pulse
    task automatic access(input logic s, input logic r, input logic [7:0] v,
                          output logic [7:0] rd, output logic oe_mid);
        @(negedge clk);
        rs = s; rw = r; din = v;
        cycles(2);
        en = 1'b1;
        cycles(5);
        rd = dout; oe_mid = oe;
        en = 1'b0;
        cycles(6);
    endtask

    // {rs, rw, busy, ac[6:0], val[7:0], exp[7:0]}
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 7'h00, 8'h38, 8'h38},
        {1'b1, 1'b0, 1'b0, 7'h00, 8'h41, 8'h41},
        {1'b0, 1'b1, 1'b1, 7'h2A, 8'h00, 8'hAA},
        {1'b1, 1'b1, 1'b0, 7'h00, 8'h00, 8'h41},
        {1'b0, 1'b0, 1'b1, 7'h10, 8'h01, 8'h01},
        {1'b0, 1'b1, 1'b0, 7'h4F, 8'h00, 8'h4F}
    };

    initial begin
        int watchdog;
        watchdog = 0;
        fork
            begin
                while (watchdog < 100000) begin @(posedge clk); watchdog++; end
                errors++;
                $display("FAIL watchdog: actual %0d expected below %0d", watchdog, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none
    end

    initial begin
        logic [7:0] rd;
        logic       om;
        int ci, cd, cr;
        cycles(4);
        rst = 1'b0;
        cycles(2);
        // R8 reset state
        check("R8 oe after reset", oe, 0);
        check("R8 no strobes", n_instr + n_dwr + n_drd, 0);
        access(1'b1, 1'b1, 8'h00, rd, om);
        check("R8 data reg reset", rd, 8'h00);
        check("R4 read strobe after read", n_drd, 1);

        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [25:0] v;
            v = VEC[k];
            busy = v[23]; ac = v[22:16];
            ci = n_instr; cd = n_dwr; cr = n_drd;
            access(v[25], v[24], v[15:8], rd, om);
            if (!v[24]) begin
                check(v[25] ? "R2 data write count" : "R1 instr write count",
                      v[25] ? n_dwr - cd : n_instr - ci, 1);
                check(v[25] ? "R2 data write byte" : (v[23] ? "R10 forward while busy" : "R1 instr byte"),
                      last_byte, v[7:0]);
                check("R7 oe low during write", om, 0);
            end else begin
                check(v[25] ? "R4 data read value" : "R3 status value", rd, v[7:0]);
                check("R7 oe high during read", om, 1);
                check("R4 read strobe count", n_drd - cr, v[25] ? 1 : 0);
            end
        end
        busy = 1'b0;
        check("R7 oe idle", oe, 0);

        // R4 refill then read
        @(negedge clk); fill_v = 1'b1; fill_b = 8'h42;
        @(negedge clk); fill_v = 1'b0;
        access(1'b1, 1'b1, 8'h00, rd, om);
        check("R4 prefetched byte read", rd, 8'h42);

        // R5 nibble write, low lines ignored
        wide = 1'b0; cycles(4);
        ci = n_instr;
        access(1'b0, 1'b0, 8'h2F, rd, om);
        check("R5 no strobe after first nibble", n_instr - ci, 0);
        access(1'b0, 1'b0, 8'h85, rd, om);
        check("R5 one strobe per byte", n_instr - ci, 1);
        check("R5 nibble byte", last_byte, 8'h28);

        // R6 nibble status
        busy = 1'b1; ac = 7'h5C;
        access(1'b0, 1'b1, 8'h00, rd, om);
        check("R6 status upper", rd, 8'hD0);
        access(1'b0, 1'b1, 8'h00, rd, om);
        check("R6 status lower", rd, 8'hC0);
        busy = 1'b0;

        // R12 nibble data write then read
        access(1'b1, 1'b0, 8'h7A, rd, om);
        access(1'b1, 1'b0, 8'hE3, rd, om);
        check("R2 nibble data byte", last_byte, 8'h7E);
        cr = n_drd;
        access(1'b1, 1'b1, 8'h00, rd, om);
        check("R12 data upper", rd, 8'h70);
        check("R12 no read strobe after first", n_drd - cr, 0);
        access(1'b1, 1'b1, 8'h00, rd, om);
        check("R12 data lower", rd, 8'hE0);
        check("R12 read strobe after second", n_drd - cr, 1);

        // R9 width toggle drops half byte
        ci = n_instr;
        access(1'b0, 1'b0, 8'h90, rd, om);
        wide = 1'b1; cycles(3);
        wide = 1'b0; cycles(3);
        access(1'b0, 1'b0, 8'h30, rd, om);
        check("R9 no strobe after restart nibble", n_instr - ci, 0);
        access(1'b0, 1'b0, 8'h10, rd, om);
        check("R9 byte after phase clear", last_byte, 8'h31);
        check("R9 strobe count", n_instr - ci, 1);

        check("R11 strobes exclusive", multi_stb, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule